// File: doc/BRIEF.md
# Code-Group Stream Scrambler and Self-Synchronising Descrambler

This block sits between a 4B5B encoder and the line coder of a 100 Mb/s twisted-pair physical layer. It handles one 5-bit code group per clock in each direction. On the transmit side every code group, whether it carries data or IDLE, is XORed bit by bit with a key stream. The key comes from an 11-stage linear feedback shift register that never looks at the data. The register is seeded with six fixed bits and the five bits of the station address.

On the receive side the descrambler has no seed of its own. It works out the far end's key stream from runs of IDLE code groups, which are all ones before scrambling. It then holds that key and keeps checking that IDLE still turns up often enough. If the line arrives inverted, IDLE descrambles to all zeros. The block spots this, inverts every incoming bit and starts acquiring again. A bypass setting, which fiber mode forces on, turns both directions into plain one-cycle pipes. The mode and the address are sampled only while the synchronous reset is held.

Top module: `symbol_scrambler`

## Requirements
- R1: With bypass off, `tx_sym_o` equals `tx_sym_i` XOR five key bits, one clock later. Bit 0 of a code group is the first bit in time. Each key bit is k = r[10] XOR r[8] of the 11-bit register r. After each bit, r shifts left with k entering r[0].
- R2: While `rst_n` is low, r is loaded with {6'b100110, `phy_addr_i`}, with the address in r[4:0]. After reset is released, changes on `phy_addr_i`, `cfg_bypass_i` and `cfg_fiber_i` have no effect until the next reset.
- R3: If `cfg_bypass_i` is high during reset, the block passes symbols straight through with one clock of latency: `tx_sym_o` follows `tx_sym_i` and `rx_sym_o` follows `rx_sym_i`. `rx_valid_o` stays at 1.
- R4: If `cfg_fiber_i` is high during reset, the block behaves as in R3 whatever the value of `cfg_bypass_i`.
- R5: While the descrambler is not locked, `rx_valid_o` is 0 and `rx_sym_o` is 5'b00000.
- R6: The descrambler locks after 30 consecutive received bits that descramble to 1. It cannot lock before its sixth code group after reset. Once locked, `rx_sym_o` is the original plain code group one clock after it arrives, with `rx_valid_o` at 1.
- R7: A run of 30 consecutive received bits that descramble to 0 during acquisition triggers the inversion path. The block toggles `rx_pol_inv_o`, spends one code group with its shift register cleared, and then acquires again on the inverted bits. After that it delivers correct data.
- R8: A locked descrambler returns to acquisition when it sees no run of 30 descrambled ones for LOSS_SYMS code groups in a row. `rx_valid_o` then falls.
- R9: While reset is held in scrambling mode, `tx_sym_o` is 0, `rx_valid_o` is 0 and `rx_pol_inv_o` is 0.
- R10: A stream of data in which an IDLE burst of at least 30 bits comes before LOSS_SYMS code groups have passed keeps `rx_valid_o` at 1 continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset; samples mode and address |
| cfg_bypass_i | input | 1 | Requests pass-through in both directions |
| cfg_fiber_i | input | 1 | Fiber mode; forces pass-through |
| phy_addr_i | input | 5 | Station address, forms the low five seed bits |
| tx_sym_i | input | 5 | Encoded code group to transmit |
| tx_sym_o | output | 5 | Scrambled code group toward the line coder |
| rx_sym_i | input | 5 | Code group recovered from the line |
| rx_sym_o | output | 5 | Descrambled code group |
| rx_valid_o | output | 1 | Descrambler locked (or bypassed) |
| rx_pol_inv_o | output | 1 | Receive bits are being inverted |

## Verification
The hardest situation to reach from the ports is the inversion path. It only happens when a scrambled IDLE stream arrives with every bit flipped. The block must first fill its register with wrong-sense bits, then count 30 consistent mismatches, then pass through the one-cycle clearing state before it can lock. The bench builds such a line with its own scrambler model running from an arbitrary seed and complements every bit. It then checks the polarity flag and the recovered data against that model. Loss of lock is reached by following a locked IDLE burst with random code groups that never contain all ones or all zeros. This means no run of 30 matches or 30 mismatches can form while the timer counts down.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic {
        TX_SCRAMBLE = 1'b0,
        TX_PASS     = 1'b1
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_PASS   = 2'd0,
        RX_HUNT   = 2'd1,
        RX_FLIP   = 2'd2,
        RX_LOCKED = 2'd3
    } rx_state_t;

    localparam int unsigned SYM_W_DEF    = 5;
    localparam int unsigned LFSR_W_DEF   = 11;
    localparam int unsigned TAP_B_DEF    = 9;
    localparam int unsigned ADDR_W_DEF   = 5;

endpackage

// File: rtl/scr_mode_latch.sv
module scr_mode_latch #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned LFSR_W = 11,
    parameter logic [LFSR_W-ADDR_W-1:0] SEED_FIXED = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_i,
    input  logic              fiber_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              bypass_o,
    output logic [LFSR_W-1:0] seed_o
);

    localparam int unsigned FIX_W = LFSR_W - ADDR_W;

    logic              bypass_live;
    logic              bypass_hold;
    logic [ADDR_W-1:0] addr_hold;
    logic [LFSR_W-1:0] seed_live;
    logic [LFSR_W-1:0] seed_hold;

    assign bypass_live = bypass_i | fiber_i;
    assign seed_live   = {SEED_FIXED[FIX_W-1:0], addr_i};
    assign seed_hold   = {SEED_FIXED[FIX_W-1:0], addr_hold};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass_hold <= bypass_live;
            addr_hold   <= addr_i;
        end
    end

    // During reset the live values flow through so a single reset cycle is enough.
    assign bypass_o = rst_n ? bypass_hold : bypass_live;
    assign seed_o   = rst_n ? seed_hold   : seed_live;

endmodule

// File: rtl/scr_tx_path.sv
module scr_tx_path
    import scr_pkg::*;
#(
    parameter int unsigned SYM_W  = 5,
    parameter int unsigned LFSR_W = 11,
    parameter int unsigned TAP_B  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_i,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic [SYM_W-1:0]  sym_i,
    output logic [SYM_W-1:0]  sym_o
);

    tx_state_t         state_q;
    tx_state_t         state_d;
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;
    logic [SYM_W-1:0]  scr_sym;
    logic [SYM_W-1:0]  sym_q;
    logic              key;

    // Next state: the mode only changes through reset.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_SCRAMBLE: state_d = TX_SCRAMBLE;
            TX_PASS:     state_d = TX_PASS;
        endcase
    end

    // Key generation, bit 0 of the code group first.
    always_comb begin
        lfsr_d  = lfsr_q;
        scr_sym = '0;
        key     = 1'b0;
        for (int i = 0; i < SYM_W; i++) begin
            key        = lfsr_d[LFSR_W-1] ^ lfsr_d[TAP_B-1];
            scr_sym[i] = sym_i[i] ^ key;
            lfsr_d     = {lfsr_d[LFSR_W-2:0], key};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= pass_i ? TX_PASS : TX_SCRAMBLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= seed_i;
            sym_q  <= '0;
        end else begin
            unique case (state_q)
                TX_SCRAMBLE: begin
                    lfsr_q <= lfsr_d;
                    sym_q  <= scr_sym;
                end
                TX_PASS: begin
                    sym_q  <= sym_i;
                end
            endcase
        end
    end

    assign sym_o = sym_q;

endmodule

// File: rtl/scr_rx_path.sv
module scr_rx_path
    import scr_pkg::*;
#(
    parameter int unsigned SYM_W     = 5,
    parameter int unsigned LFSR_W    = 11,
    parameter int unsigned TAP_B     = 9,
    parameter int unsigned LOCK_BITS = 30,
    parameter int unsigned POL_BITS  = 30,
    parameter int unsigned LOSS_SYMS = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] sym_o,
    output logic             valid_o,
    output logic             pol_inv_o
);

    localparam int unsigned RUN_MAX = (LOCK_BITS > POL_BITS) ? LOCK_BITS : POL_BITS;
    localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
    localparam int unsigned TMR_W   = $clog2(LOSS_SYMS + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX);
    localparam logic [RUN_W-1:0] LOCK_C  = RUN_W'(LOCK_BITS);
    localparam logic [RUN_W-1:0] POL_C   = RUN_W'(POL_BITS);
    localparam logic [TMR_W-1:0] LOSS_C  = TMR_W'(LOSS_SYMS);

    rx_state_t         state_q;
    rx_state_t         state_d;
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;
    logic [RUN_W-1:0]  one_run_q;
    logic [RUN_W-1:0]  one_run_d;
    logic [RUN_W-1:0]  zero_run_q;
    logic [RUN_W-1:0]  zero_run_d;
    logic [TMR_W-1:0]  tmr_q;
    logic [TMR_W-1:0]  tmr_inc;
    logic              inv_q;
    logic [SYM_W-1:0]  sym_eff;
    logic [SYM_W-1:0]  plain;
    logic [SYM_W-1:0]  sym_q;
    logic              valid_q;
    logic              hunting;
    logic              idle_seen;
    logic              lock_hit;
    logic              flip_hit;
    logic              expire;
    logic              pred;
    logic              dbit;

    assign sym_eff = inv_q ? ~sym_i : sym_i;
    assign hunting = (state_q == RX_HUNT);

    // Bit-serial descrambling with run tracking over one code group.
    always_comb begin
        lfsr_d     = lfsr_q;
        one_run_d  = one_run_q;
        zero_run_d = zero_run_q;
        plain      = '0;
        pred       = 1'b0;
        dbit       = 1'b0;
        for (int i = 0; i < SYM_W; i++) begin
            pred     = lfsr_d[LFSR_W-1] ^ lfsr_d[TAP_B-1];
            dbit     = sym_eff[i] ^ pred;
            plain[i] = dbit;
            if (hunting) begin
                lfsr_d = {lfsr_d[LFSR_W-2:0], ~sym_eff[i]};
            end else begin
                lfsr_d = {lfsr_d[LFSR_W-2:0], pred};
            end
            if (dbit) begin
                zero_run_d = '0;
                if (one_run_d != RUN_SAT) one_run_d = one_run_d + RUN_W'(1);
            end else begin
                one_run_d = '0;
                if (zero_run_d != RUN_SAT) zero_run_d = zero_run_d + RUN_W'(1);
            end
        end
    end

    assign lock_hit  = (one_run_d >= LOCK_C);
    assign flip_hit  = (zero_run_d >= POL_C);
    assign idle_seen = (one_run_d >= LOCK_C);
    assign tmr_inc   = tmr_q + TMR_W'(1);
    assign expire    = !idle_seen && (tmr_inc >= LOSS_C);

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_PASS:   state_d = RX_PASS;
            RX_HUNT: begin
                if (lock_hit)      state_d = RX_LOCKED;
                else if (flip_hit) state_d = RX_FLIP;
            end
            RX_FLIP:   state_d = RX_HUNT;
            RX_LOCKED: if (expire) state_d = RX_HUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= pass_i ? RX_PASS : RX_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q     <= '0;
            one_run_q  <= '0;
            zero_run_q <= '0;
            tmr_q      <= '0;
            inv_q      <= 1'b0;
            sym_q      <= '0;
            valid_q    <= pass_i;
        end else begin
            unique case (state_q)
                RX_PASS: begin
                    sym_q   <= sym_i;
                    valid_q <= 1'b1;
                end
                RX_HUNT: begin
                    lfsr_q     <= lfsr_d;
                    one_run_q  <= lock_hit ? one_run_d : (flip_hit ? '0 : one_run_d);
                    zero_run_q <= flip_hit ? '0 : zero_run_d;
                    tmr_q      <= '0;
                    sym_q      <= '0;
                    valid_q    <= 1'b0;
                end
                RX_FLIP: begin
                    lfsr_q     <= '0;
                    one_run_q  <= '0;
                    zero_run_q <= '0;
                    inv_q      <= ~inv_q;
                    sym_q      <= '0;
                    valid_q    <= 1'b0;
                end
                RX_LOCKED: begin
                    lfsr_q     <= lfsr_d;
                    one_run_q  <= expire ? '0 : one_run_d;
                    zero_run_q <= '0;
                    tmr_q      <= (idle_seen || expire) ? '0 : tmr_inc;
                    sym_q      <= plain;
                    valid_q    <= 1'b1;
                end
            endcase
        end
    end

    assign sym_o     = sym_q;
    assign valid_o   = valid_q;
    assign pol_inv_o = inv_q;

endmodule

// File: rtl/symbol_scrambler.sv
module symbol_scrambler
    import scr_pkg::*;
#(
    parameter int unsigned SYM_W     = SYM_W_DEF,
    parameter int unsigned LFSR_W    = LFSR_W_DEF,
    parameter int unsigned TAP_B     = TAP_B_DEF,
    parameter int unsigned ADDR_W    = ADDR_W_DEF,
    parameter logic [LFSR_W-ADDR_W-1:0] SEED_FIXED = 6'b100110,
    parameter int unsigned LOCK_BITS = 30,
    parameter int unsigned POL_BITS  = 30,
    parameter int unsigned LOSS_SYMS = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass_i,
    input  logic              cfg_fiber_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [SYM_W-1:0]  tx_sym_i,
    output logic [SYM_W-1:0]  tx_sym_o,
    input  logic [SYM_W-1:0]  rx_sym_i,
    output logic [SYM_W-1:0]  rx_sym_o,
    output logic              rx_valid_o,
    output logic              rx_pol_inv_o
);

    logic              mode_bypass;
    logic [LFSR_W-1:0] tx_seed;

    scr_mode_latch #(
        .ADDR_W     (ADDR_W),
        .LFSR_W     (LFSR_W),
        .SEED_FIXED (SEED_FIXED)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass_i (cfg_bypass_i),
        .fiber_i  (cfg_fiber_i),
        .addr_i   (phy_addr_i),
        .bypass_o (mode_bypass),
        .seed_o   (tx_seed)
    );

    scr_tx_path #(
        .SYM_W  (SYM_W),
        .LFSR_W (LFSR_W),
        .TAP_B  (TAP_B)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (mode_bypass),
        .seed_i (tx_seed),
        .sym_i  (tx_sym_i),
        .sym_o  (tx_sym_o)
    );

    scr_rx_path #(
        .SYM_W     (SYM_W),
        .LFSR_W    (LFSR_W),
        .TAP_B     (TAP_B),
        .LOCK_BITS (LOCK_BITS),
        .POL_BITS  (POL_BITS),
        .LOSS_SYMS (LOSS_SYMS)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pass_i    (mode_bypass),
        .sym_i     (rx_sym_i),
        .sym_o     (rx_sym_o),
        .valid_o   (rx_valid_o),
        .pol_inv_o (rx_pol_inv_o)
    );

endmodule

// File: rtl/symbol_scrambler_chk.sv
module symbol_scrambler_chk #(
    parameter int unsigned SYM_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_bypass,
    input logic [SYM_W-1:0] tx_sym_i,
    input logic [SYM_W-1:0] tx_sym_o,
    input logic [SYM_W-1:0] rx_sym_i,
    input logic [SYM_W-1:0] rx_sym_o,
    input logic             rx_valid_o,
    input logic             rx_pol_inv_o
);

    // R3, R4: pass-through transmit path
    a_r3_tx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bypass && $past(rst_n)) |-> (tx_sym_o == $past(tx_sym_i)));

    // R3, R4: pass-through receive path
    a_r3_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bypass && $past(rst_n)) |-> (rx_valid_o && rx_sym_o == $past(rx_sym_i)));

    // R5: nothing leaves the receive side while unlocked
    a_r5_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> (rx_sym_o == '0));

    // R7: the polarity flag moves only while output is invalid
    a_r7_flip_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_pol_inv_o) |-> !rx_valid_o);

    // R2: the mode sampled in reset holds afterwards
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_bypass));

    // R9: first cycle after a scrambling-mode reset starts clean
    a_r9_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !mode_bypass) |-> (tx_sym_o == '0 && !rx_valid_o && !rx_pol_inv_o));

endmodule

bind symbol_scrambler symbol_scrambler_chk #(.SYM_W(SYM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_bypass  (mode_bypass),
    .tx_sym_i     (tx_sym_i),
    .tx_sym_o     (tx_sym_o),
    .rx_sym_i     (rx_sym_i),
    .rx_sym_o     (rx_sym_o),
    .rx_valid_o   (rx_valid_o),
    .rx_pol_inv_o (rx_pol_inv_o)
);

// File: tb/symbol_scrambler_tb_top.sv
`timescale 1ns/100ps
module symbol_scrambler_tb_top;

    localparam int LOSS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_bypass_i = 1'b0;
    logic       cfg_fiber_i = 1'b0;
    logic [4:0] phy_addr_i = '0;
    logic [4:0] tx_sym_i = '0;
    logic [4:0] tx_sym_o;
    logic [4:0] rx_sym_i = '0;
    logic [4:0] rx_sym_o;
    logic       rx_valid_o;
    logic       rx_pol_inv_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [10:0] mt;
    logic [10:0] mr;
    string tx_tag = "R1";
    string rx_tag = "R6";

    always #2.5 clk = ~clk;

    symbol_scrambler #(.LOSS_SYMS(LOSS)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_bypass_i (cfg_bypass_i),
        .cfg_fiber_i  (cfg_fiber_i),
        .phy_addr_i   (phy_addr_i),
        .tx_sym_i     (tx_sym_i),
        .tx_sym_o     (tx_sym_o),
        .rx_sym_i     (rx_sym_i),
        .rx_sym_o     (rx_sym_o),
        .rx_valid_o   (rx_valid_o),
        .rx_pol_inv_o (rx_pol_inv_o)
    );

    function automatic logic [15:0] scr_step(input logic [10:0] st, input logic [4:0] p);
        logic [4:0] o;
        logic k;
        for (int i = 0; i < 5; i++) begin
            k    = st[10] ^ st[8];
            o[i] = p[i] ^ k;
            st   = {st[9:0], k};
        end
        return {st, o};
    endfunction

    function automatic logic [4:0] rnd_data();
        return 5'($urandom_range(1, 30));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset(input bit byp, input bit fib, input logic [4:0] addr);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_bypass_i = byp;
        cfg_fiber_i  = fib;
        phy_addr_i   = addr;
        tx_sym_i = '0;
        rx_sym_i = '0;
        repeat (3) @(negedge clk);
        if (!(byp || fib)) begin
            check(tx_sym_o == 5'd0, "R9", tx_sym_o, 0);
            check(rx_valid_o == 1'b0, "R9", rx_valid_o, 0);
            check(rx_pol_inv_o == 1'b0, "R9", rx_pol_inv_o, 0);
        end
        mt = {6'b100110, addr};
        mr = 11'h2D5;
        rst_n = 1'b1;
    endtask

    // One code group each way; output is sampled at the next falling edge.
    task automatic cycle(input logic [4:0] tp, input logic [4:0] pp, input bit inv, input bit byp);
        logic [15:0] r;
        logic [4:0]  tx_exp;
        logic [4:0]  line;
        if (byp) begin
            tx_exp = tp;
            line   = pp;
        end else begin
            r = scr_step(mt, tp);
            mt = r[15:5];
            tx_exp = r[4:0];
            r = scr_step(mr, pp);
            mr = r[15:5];
            line = inv ? ~r[4:0] : r[4:0];
        end
        tx_sym_i = tp;
        rx_sym_i = line;
        @(posedge clk);
        @(negedge clk);
        check(tx_sym_o == tx_exp, tx_tag, tx_sym_o, tx_exp);
        if (rx_valid_o) check(rx_sym_o == pp, rx_tag, rx_sym_o, pp);
        else check(rx_sym_o == 5'd0, "R5", rx_sym_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        bit ever_valid;
        void'($urandom(32'd4242));

        // R1, R5, R6, R10, R2: normal polarity acquisition and data
        do_reset(1'b0, 1'b0, 5'h13);
        ever_valid = 1'b0;
        for (int i = 0; i < 303; i++) begin
            int ph;
            logic [4:0] pp;
            ph = (i - 40) % 33;
            pp = (i < 40 || ph >= 25) ? 5'h1F : rnd_data();
            if (i == 100) begin
                phy_addr_i   = 5'h0A;
                cfg_bypass_i = 1'b1;
                tx_tag = "R2";
            end
            rx_tag = (i >= 40) ? "R10" : "R6";
            cycle(rnd_data(), pp, 1'b0, 1'b0);
            if (i <= 5) check(rx_valid_o == 1'b0, "R5", rx_valid_o, 0);
            if (i == 25) check(rx_valid_o == 1'b1, "R6", rx_valid_o, 1);
            if (ever_valid) check(rx_valid_o == 1'b1, "R10", rx_valid_o, 1);
            if (rx_valid_o) ever_valid = 1'b1;
        end
        check(rx_pol_inv_o == 1'b0, "R7", rx_pol_inv_o, 0);

        // R8: no idle runs, lock must drop after LOSS code groups
        tx_tag = "R2";
        rx_tag = "R8";
        for (int i = 0; i < LOSS + 10; i++) begin
            cycle(rnd_data(), rnd_data(), 1'b0, 1'b0);
            if (i == LOSS - 6) check(rx_valid_o == 1'b1, "R8", rx_valid_o, 1);
            if (i == LOSS + 6) check(rx_valid_o == 1'b0, "R8", rx_valid_o, 0);
        end

        // R7: inverted line
        do_reset(1'b0, 1'b0, 5'h05);
        tx_tag = "R1";
        rx_tag = "R7";
        for (int i = 0; i < 130; i++) begin
            cycle(rnd_data(), (i < 70) ? 5'h1F : rnd_data(), 1'b1, 1'b0);
            if (i == 5) check(rx_pol_inv_o == 1'b0, "R7", rx_pol_inv_o, 0);
            if (i == 69) begin
                check(rx_pol_inv_o == 1'b1, "R7", rx_pol_inv_o, 1);
                check(rx_valid_o == 1'b1, "R7", rx_valid_o, 1);
            end
        end

        // R3: bypass requested, later deassertion has no effect
        do_reset(1'b1, 1'b0, 5'h1C);
        tx_tag = "R3";
        rx_tag = "R3";
        for (int i = 0; i < 50; i++) begin
            if (i == 10) cfg_bypass_i = 1'b0;
            cycle(5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), 1'b0, 1'b1);
            check(rx_valid_o == 1'b1, "R3", rx_valid_o, 1);
        end

        // R4: fiber mode forces bypass
        do_reset(1'b0, 1'b1, 5'h01);
        tx_tag = "R4";
        rx_tag = "R4";
        for (int i = 0; i < 50; i++) begin
            cycle(5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), 1'b0, 1'b1);
            check(rx_valid_o == 1'b1, "R4", rx_valid_o, 1);
        end

        // R2: a new reset picks up the new address
        do_reset(1'b0, 1'b0, 5'h1E);
        tx_tag = "R2";
        rx_tag = "R6";
        for (int i = 0; i < 40; i++) begin
            cycle(5'($urandom_range(0, 31)), 5'h1F, 1'b0, 1'b0);
        end
        check(rx_valid_o == 1'b1, "R6", rx_valid_o, 1);

        summary();
    end

endmodule